// File: doc/BRIEF.md
# Reconfiguration Stream Loader

This block sits between a register-style software interface and an internal reconfiguration engine. Software pushes 32-bit programming words into a data port. The words wait in an on-chip queue and move to the engine over a valid/ready stream. A separate control/status word tells software four things: how many more words it may write, whether the engine reports ready or done, where the current programming run stands (a 3-bit code), and whether a request is still outstanding.

To start a run, software writes the control word with its top bit set. The run is active while the status code is in-progress. Only during that time does the queue drain toward the engine. Words written earlier are held until the run starts. The engine ends a run by raising one of four inputs: done, CRC error, incompatible stream or generic programming error. A data write that arrives while the queue is full is discarded. It raises an overflow flag and aborts the run with a programming error. Hardware clears the request bit whenever a run ends.

Top module: `cfg_stream_loader`

## Requirements
- R1: Bits 15:0 of `ctrl_rdata` give the number of further words the data port can accept, DEPTH minus the words queued. After reset this is DEPTH (16 by default). An accepted write lowers it by one from the next cycle on, and a word taken by the engine raises it by one.
- R2: Bit 16 of `ctrl_rdata` equals `eng_ready` and bit 17 equals `eng_done` in the same cycle.
- R3: Bits 20:18 of `ctrl_rdata` hold the status code: 000 idle/reset, 001 programming error, 010 CRC error, 011 incompatible stream, 100 in progress, 101 success. Codes 110 and 111 never occur. After reset the whole word reads 0x00000010 when the engine inputs are low.
- R4: A control write with bit 31 set, made while the status is not 100, sets bit 31 and clears the overflow flag. If `eng_ready` is high in the write cycle, the status becomes 100 on the next cycle. Otherwise it becomes 000, and it moves to 100 one cycle after `eng_ready` is seen high while the request is pending. Any earlier error or success code is replaced by this.
- R5: While the status is 100, the engine inputs end the run with this priority: CRC error (010), then incompatible stream (011), then programming error (001), then done (101). The new code and a cleared bit 31 appear on the next cycle.
- R6: A data-port write made while the queue holds DEPTH words is dropped and the dropped word never reaches the stream. On the next cycle the status reads 001, bit 31 reads 0 and `overflow` reads 1. This takes precedence over any engine input or control write in the same cycle.
- R7: `out_valid` is high only while the status is 100 and the queue is not empty. Words leave in the order they were written, one per cycle in which `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_data` holds its value.
- R8: Bits 30:21 of `ctrl_rdata` always read 0. A control write with bit 31 clear has no effect, and neither does a request write made while the status is 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_wr | input | 1 | Write strobe for the programming data port |
| data_wdata | input | 32 | Programming word |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control write value; only bit 31 (request) is used |
| ctrl_rdata | output | 32 | Control/status readout |
| overflow | output | 1 | A data word was dropped on a full queue; cleared by the next accepted request |
| out_valid | output | 1 | Stream word available to the engine |
| out_data | output | 32 | Stream word |
| out_ready | input | 1 | Engine accepts the stream word |
| eng_ready | input | 1 | Engine ready to be programmed |
| eng_done | input | 1 | Engine finished successfully |
| eng_crc_err | input | 1 | Engine detected a CRC error |
| eng_incompat | input | 1 | Engine rejected the stream as incompatible |
| eng_prog_err | input | 1 | Engine reported a generic programming error |

## Verification
The embedded properties watch, on every cycle, the invariants of the loader. The status never takes a reserved code. The request bit is gone whenever a run leaves the in-progress state. Entry into in-progress always follows a sampled engine-ready. The queue occupancy never exceeds its depth or jumps by more than one. A stalled stream word stays put. A full-queue write always lands in programming error with the overflow flag set.

Only the bench's scenarios can show the rest. These are the order in which words leave and the end-code priority when several engine inputs rise together. They also cover the pending request that waits for ready, the dropped word never reappearing on the stream, and the overflow flag being cleared by a fresh request.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int DATA_W = 32;
    localparam int FREE_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'b000,
        ST_PERR     = 3'b001,
        ST_CRC      = 3'b010,
        ST_INCOMPAT = 3'b011,
        ST_PROG     = 3'b100,
        ST_OK       = 3'b101
    } ldr_status_e;

    typedef struct packed {
        ldr_status_e sts;
        logic        req;
        logic        ovf;
    } ldr_ctrl_t;

endpackage

// File: rtl/cfgl_fifo.sv
module cfgl_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [CW-1:0]    free_cnt,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + AW'(1);
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + AW'(1);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[st_q.wr] <= push_data;
        end
    end

    assign head_data = mem_q[st_q.rd];
    assign free_cnt  = CW'(DEPTH) - st_q.cnt;

    // R1: occupancy bounded and moves by at most one word per cycle
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == $past(st_q.cnt)) || (st_q.cnt == $past(st_q.cnt) + CW'(1))
        || (st_q.cnt + CW'(1) == $past(st_q.cnt)));

endmodule

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
    import cfgl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_wr,
    input  logic       ovf_evt,
    input  logic       eng_ready,
    input  logic       eng_done,
    input  logic       eng_crc_err,
    input  logic       eng_incompat,
    input  logic       eng_prog_err,
    output logic [2:0] sts,
    output logic       req,
    output logic       ovf,
    output logic       busy
);

    ldr_ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ovf_evt) begin
            st_d.sts = ST_PERR;
            st_d.req = 1'b0;
            st_d.ovf = 1'b1;
        end else if (st_q.sts == ST_PROG) begin
            if (eng_crc_err) begin
                st_d.sts = ST_CRC;
                st_d.req = 1'b0;
            end else if (eng_incompat) begin
                st_d.sts = ST_INCOMPAT;
                st_d.req = 1'b0;
            end else if (eng_prog_err) begin
                st_d.sts = ST_PERR;
                st_d.req = 1'b0;
            end else if (eng_done) begin
                st_d.sts = ST_OK;
                st_d.req = 1'b0;
            end
        end else if (req_wr) begin
            st_d.req = 1'b1;
            st_d.ovf = 1'b0;
            st_d.sts = eng_ready ? ST_PROG : ST_IDLE;
        end else if (st_q.req && eng_ready) begin
            st_d.sts = ST_PROG;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{sts: ST_IDLE, req: 1'b0, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sts  = st_q.sts;
    assign req  = st_q.req;
    assign ovf  = st_q.ovf;
    assign busy = (st_q.sts == ST_PROG);

    // R3: reserved codes never reached
    a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts != 3'b110) && (st_q.sts != 3'b111));
    // R5: leaving in-progress always drops the request
    a_r5_req_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.sts) == ST_PROG) && (st_q.sts != ST_PROG) |-> !st_q.req);
    // R4: entry into in-progress only after ready was sampled
    a_r4_entry_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts == ST_PROG) && ($past(st_q.sts) != ST_PROG) |-> $past(eng_ready));

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
    import cfgl_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        data_wr,
    input  logic [31:0] data_wdata,
    input  logic        ctrl_wr,
    input  logic [31:0] ctrl_wdata,
    output logic [31:0] ctrl_rdata,
    output logic        overflow,
    output logic        out_valid,
    output logic [31:0] out_data,
    input  logic        out_ready,
    input  logic        eng_ready,
    input  logic        eng_done,
    input  logic        eng_crc_err,
    input  logic        eng_incompat,
    input  logic        eng_prog_err
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] fifo_free;
    logic          fifo_full, fifo_empty;
    logic          fifo_push, fifo_pop;
    logic          req_wr, ovf_evt;
    logic [2:0]    sts;
    logic          req, busy;
    logic          unused_wbits;

    assign unused_wbits = ^ctrl_wdata[30:0];
    assign req_wr    = ctrl_wr && ctrl_wdata[31];
    assign ovf_evt   = data_wr && fifo_full;
    assign fifo_push = data_wr && !fifo_full;
    assign out_valid = busy && !fifo_empty;
    assign fifo_pop  = out_valid && out_ready;

    cfgl_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (data_wdata),
        .pop       (fifo_pop),
        .head_data (out_data),
        .free_cnt  (fifo_free),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    cfgl_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_wr       (req_wr),
        .ovf_evt      (ovf_evt),
        .eng_ready    (eng_ready),
        .eng_done     (eng_done),
        .eng_crc_err  (eng_crc_err),
        .eng_incompat (eng_incompat),
        .eng_prog_err (eng_prog_err),
        .sts          (sts),
        .req          (req),
        .ovf          (overflow),
        .busy         (busy)
    );

    assign ctrl_rdata = {req, 10'd0, sts, eng_done, eng_ready, FREE_W'(fifo_free)};

    // R7: a stalled stream word does not change
    a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (!out_valid || $stable(out_data)));
    // R6: a write on a full queue aborts with a programming error
    a_r6_overflow_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && fifo_full) |=> (sts == 3'b001) && overflow && !req);

endmodule

// File: tb/cfg_stream_loader_tb.sv
module cfg_stream_loader_tb;

    localparam int CLK_P = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        data_wr = 1'b0;
    logic [31:0] data_wdata = '0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic        overflow;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b0;
    logic        eng_ready = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_crc_err = 1'b0;
    logic        eng_incompat = 1'b0;
    logic        eng_prog_err = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    cfg_stream_loader #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .data_wr(data_wr), .data_wdata(data_wdata),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .overflow(overflow),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .eng_ready(eng_ready), .eng_done(eng_done), .eng_crc_err(eng_crc_err),
        .eng_incompat(eng_incompat), .eng_prog_err(eng_prog_err)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
        end
    endtask

    // reference model
    int unsigned mq[$];
    bit          m_req, m_ovf;
    logic [2:0]  m_sts;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_req = 0; m_ovf = 0; m_sts = 3'b000;
        end else begin
            bit pop, full, ovf;
            pop  = (m_sts == 3'b100) && (mq.size() > 0) && out_ready;
            full = (mq.size() >= DEPTH);
            ovf  = data_wr && full;
            if (pop) void'(mq.pop_front());
            if (data_wr && !full) mq.push_back(data_wdata);
            if (ovf) begin
                m_sts = 3'b001; m_req = 0; m_ovf = 1;
            end else if (m_sts == 3'b100) begin
                if (eng_crc_err)       begin m_sts = 3'b010; m_req = 0; end
                else if (eng_incompat) begin m_sts = 3'b011; m_req = 0; end
                else if (eng_prog_err) begin m_sts = 3'b001; m_req = 0; end
                else if (eng_done)     begin m_sts = 3'b101; m_req = 0; end
            end else if (ctrl_wr && ctrl_wdata[31]) begin
                m_req = 1; m_ovf = 0;
                m_sts = eng_ready ? 3'b100 : 3'b000;
            end else if (m_req && eng_ready) begin
                m_sts = 3'b100;
            end
        end
        #(CLK_P/4);
        if (!finished) begin
            chk("R1 free", 32'(ctrl_rdata[15:0]), DEPTH - mq.size());
            chk("R2 ready", 32'(ctrl_rdata[16]), 32'(eng_ready));
            chk("R2 done", 32'(ctrl_rdata[17]), 32'(eng_done));
            chk("R3 status", 32'(ctrl_rdata[20:18]), 32'(m_sts));
            chk("R4 req", 32'(ctrl_rdata[31]), 32'(m_req));
            chk("R8 zero", 32'(ctrl_rdata[30:21]), 32'd0);
            chk("R6 overflow", 32'(overflow), 32'(m_ovf));
            chk("R7 valid", 32'(out_valid), 32'((m_sts == 3'b100) && (mq.size() > 0)));
            if (m_sts == 3'b100 && mq.size() > 0) chk("R7 data", out_data, mq[0]);
        end
    end

    task automatic dwr(input logic [31:0] v);
        @(negedge clk); data_wr = 1; data_wdata = v;
        @(negedge clk); data_wr = 0;
    endtask

    task automatic cwr(input logic [31:0] v);
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 0;
    endtask

    task automatic pulse(input logic c, input logic i, input logic p, input logic d);
        @(negedge clk); eng_crc_err = c; eng_incompat = i; eng_prog_err = p; eng_done = d;
        @(negedge clk); eng_crc_err = 0; eng_incompat = 0; eng_prog_err = 0; eng_done = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        chk("R3 reset word", ctrl_rdata, 32'h0000_0010);
        chk("R7 reset valid", 32'(out_valid), 0);

        for (int k = 0; k < 3; k++) dwr(32'hA000_0000 + k);
        chk("R1 three queued", 32'(ctrl_rdata[15:0]), 13);
        chk("R7 held before run", 32'(out_valid), 0);

        cwr(32'h7FFF_FFFF);
        chk("R8 write without request", ctrl_rdata, 32'h0000_000D);

        cwr(32'h8000_0000);
        chk("R4 pending req", ctrl_rdata[31:18], 14'h2000);

        @(negedge clk); eng_ready = 1;
        @(negedge clk);
        chk("R4 enters progress", 32'(ctrl_rdata[20:18]), 3'b100);
        chk("R7 first word", out_data, 32'hA000_0000);
        chk("R2 ready bit", 32'(ctrl_rdata[16]), 1);
        idle(2);
        chk("R7 stalled word", out_data, 32'hA000_0000);

        out_ready = 1;
        idle(4);
        chk("R1 drained", 32'(ctrl_rdata[15:0]), 16);
        chk("R7 empty", 32'(out_valid), 0);

        cwr(32'h8000_0000);
        chk("R8 request in progress", 32'(ctrl_rdata[20:18]), 3'b100);

        pulse(0, 0, 0, 1);
        chk("R5 done", ctrl_rdata[31:18], 14'h0005);

        cwr(32'h8000_0000);
        chk("R4 clears success", ctrl_rdata[31:18], 14'h2004);
        pulse(1, 0, 0, 1);
        chk("R5 crc over done", ctrl_rdata[31:18], 14'h0002);

        cwr(32'h8000_0000);
        pulse(0, 1, 1, 0);
        chk("R5 incompat over error", ctrl_rdata[31:18], 14'h0003);

        cwr(32'h8000_0000);
        pulse(0, 0, 1, 0);
        chk("R5 prog error", ctrl_rdata[31:18], 14'h0001);

        out_ready = 0;
        cwr(32'h8000_0000);
        for (int k = 0; k < DEPTH; k++) dwr(32'hB000_0000 + k);
        chk("R1 full", 32'(ctrl_rdata[15:0]), 0);
        dwr(32'hDEAD_BEEF);
        chk("R6 status", ctrl_rdata[31:18], 14'h0001);
        chk("R6 flag", 32'(overflow), 1);
        chk("R6 still full", 32'(ctrl_rdata[15:0]), 0);

        cwr(32'h8000_0000);
        chk("R6 flag cleared", 32'(overflow), 0);
        chk("R4 restart", 32'(ctrl_rdata[20:18]), 3'b100);
        chk("R7 order after overflow", out_data, 32'hB000_0000);
        out_ready = 1;
        idle(DEPTH + 2);
        chk("R6 dropped word absent", 32'(ctrl_rdata[15:0]), 16);
        pulse(0, 0, 0, 1);
        chk("R5 final done", 32'(ctrl_rdata[20:18]), 3'b101);

        idle(2);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule